// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept or dropped, based on its destination address. The first six bytes of the frame are taken from a byte stream that carries a valid strobe and a start-of-frame flag. They are compared against several criteria:

- two programmable unicast addresses,
- the all-ones broadcast address,
- a 64-entry group table indexed by a 6-bit hash of the address.

A preliminary match result is available one cycle after the sixth address byte. When the frame ends, the receive path presents the frame length. The block then reports a final verdict, which also rejects frames that are too short to hold both address fields.

Each of the four match sources has its own enable bit, and the frame is accepted if any enabled source matches. The group hash normally applies only to group (multicast) addresses. An option lets it also apply to individual addresses, which gives an imperfect hash filter for unicast traffic.

Top module: `rx_dest_filter`

## Requirements
- R1: With `ctrl[0]` set, a destination equal to unicast slot 0 matches. Slot 0 is packed so that byte 0 on the wire is `uc0_lo[7:0]`, byte 3 is `uc0_lo[31:24]`, byte 4 is `uc0_hi[7:0]` and byte 5 is `uc0_hi[15:8]`. With `ctrl[0]` clear, slot 0 never matches.
- R2: With `ctrl[1]` set, a destination equal to unicast slot 1 matches. Slot 1 uses the same packing with `uc1_lo`/`uc1_hi`. With `ctrl[1]` clear, slot 1 never matches.
- R3: With `ctrl[3]` set, the destination FF:FF:FF:FF:FF:FF matches. With `ctrl[3]` clear, broadcast gets no special treatment.
- R4: The hash index is formed in three steps:
  - Number the 48 address bits k = 0..47, where bit k is bit k%8 of byte k/8 (byte 0 arrives first).
  - Hash bit j is the XOR of all address bits with k%6 == j.
  - Index 32..63 selects `tbl_hi[index-32]`, and index 0..31 selects `tbl_lo[index]`. The selected table bit set means a hash match.
- R5: The hash test counts only when bit 0 of byte 0 (the group bit) is set or `ctrl[2]` is set. Otherwise it yields no match.
- R6: The match result is the OR of the enabled slot 0, slot 1, broadcast and hash results.
- R7: `match_valid` pulses for exactly one cycle, one clock after the sixth byte that follows a start-of-frame. `match_hit` is high only during that pulse and gives the match result. Bytes after the sixth, and bytes before any start-of-frame, are ignored.
- R8: One clock after `eof_valid`, `verdict_valid` pulses. `verdict_accept` is high only if the match result of the frame was a hit and `frame_len` is at least 12. A frame that ended before its sixth byte is rejected.
- R9: A start-of-frame byte restarts address capture, discarding any partially received address and any earlier match result.
- R10: After reset, `match_valid`, `match_hit`, `verdict_valid` and `verdict_accept` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe for `in_byte` |
| in_sof | input | 1 | Marks the first byte of a frame (qualified by `in_valid`) |
| in_byte | input | 8 | Received frame byte |
| eof_valid | input | 1 | End of frame; `frame_len` is valid |
| frame_len | input | 16 | Frame length in bytes |
| ctrl | input | 4 | bit0 slot 0 enable, bit1 slot 1 enable, bit2 hash individual addresses, bit3 broadcast enable |
| uc0_lo | input | 32 | Slot 0 bytes 0..3, byte 0 in bits 7:0 |
| uc0_hi | input | 16 | Slot 0 bytes 4..5, byte 4 in bits 7:0 |
| uc1_lo | input | 32 | Slot 1 bytes 0..3 |
| uc1_hi | input | 16 | Slot 1 bytes 4..5 |
| tbl_lo | input | 32 | Group table entries 0..31 |
| tbl_hi | input | 32 | Group table entries 32..63 |
| match_valid | output | 1 | Address match result valid |
| match_hit | output | 1 | Address match result |
| verdict_valid | output | 1 | Final verdict valid |
| verdict_accept | output | 1 | Frame accepted |

## Verification
The bench builds the block with its defaults: a 16-bit length field and a minimum length of 12. This keeps the length boundary at 11/12/13 within a few stimulus values.

All sixteen control settings are swept against three table fills: all zero, all one, and a single entry at the address's own hash. For each combination, the bench sends slot addresses, broadcast, near-miss and random group and individual addresses. These runs compare match and verdict against an arithmetic model of the filter.

A further 64-address hash sweep sets one table entry at the computed index and at a neighbouring index. This exercises every fold position of the hash. It also covers the extra-byte, restart and short-frame timing cases.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int MAC_BYTES = 6;
    localparam int MAC_BITS  = 8 * MAC_BYTES;
    localparam int TBL_SIZE  = 64;
    localparam int HASH_W    = $clog2(TBL_SIZE);
    localparam int FOLDS     = MAC_BITS / HASH_W;

    typedef logic [MAC_BITS-1:0] mac_t;
    typedef logic [HASH_W-1:0]   hidx_t;

    // Packed so that bit position equals the control input bit.
    typedef struct packed {
        logic bcast_en;
        logic hash_indiv;
        logic uc1_en;
        logic uc0_en;
    } filt_ctrl_t;

    // Wire order: byte 0 first, LSB first; folded in 6-bit slices.
    function automatic hidx_t fold_hash(input mac_t a);
        hidx_t h;
        h = '0;
        for (int g = 0; g < FOLDS; g++) begin
            h = h ^ a[HASH_W*g +: HASH_W];
        end
        return h;
    endfunction

    function automatic mac_t pack_addr(input logic [31:0] lo, input logic [15:0] hi);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/rxf_addr_capture.sv
module rxf_addr_capture
    import rxf_pkg::*;
#(
    parameter int BYTES = MAC_BYTES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_sof,
    input  logic [7:0]   in_byte,
    output mac_t         addr,
    output logic         addr_done
);
    localparam int CW = $clog2(BYTES + 1);
    localparam logic [CW-1:0] LAST = CW'(BYTES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            addr      <= '0;
            addr_done <= 1'b0;
        end else begin
            addr_done <= 1'b0;
            if (in_valid) begin
                if (in_sof) begin
                    addr      <= '0;
                    addr[7:0] <= in_byte;
                    cnt       <= CW'(1);
                    addr_done <= (BYTES == 1);
                end else if (cnt != '0 && cnt < CW'(BYTES)) begin
                    addr[8*int'(cnt) +: 8] <= in_byte;
                    cnt       <= cnt + 1'b1;
                    addr_done <= (cnt == LAST);
                end
            end
        end
    end

    assert_done_follows_byte_R7: assert property (@(posedge clk) disable iff (rst)
        addr_done |-> $past(in_valid));
    assert_done_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        addr_done |=> !addr_done);

endmodule

// File: rtl/rxf_match.sv
module rxf_match
    import rxf_pkg::*;
(
    input  mac_t                addr,
    input  filt_ctrl_t          ctrl,
    input  mac_t                uc0,
    input  mac_t                uc1,
    input  logic [TBL_SIZE-1:0] tbl,
    output logic                hit
);
    localparam int SLOTS = 2;

    mac_t             slot_addr [SLOTS];
    logic [SLOTS-1:0] slot_en;
    logic [SLOTS-1:0] slot_hit;
    logic             bcast_hit;
    logic             hash_hit;
    hidx_t            idx;

    assign slot_addr[0] = uc0;
    assign slot_addr[1] = uc1;
    assign slot_en      = {ctrl.uc1_en, ctrl.uc0_en};

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        assign slot_hit[i] = slot_en[i] && (addr == slot_addr[i]);
    end

    assign bcast_hit = ctrl.bcast_en && (&addr);
    assign idx       = fold_hash(addr);
    assign hash_hit  = (addr[0] || ctrl.hash_indiv) && tbl[idx];
    assign hit       = (|slot_hit) || bcast_hit || hash_hit;

endmodule

// File: rtl/rxf_verdict.sv
module rxf_verdict #(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             addr_done,
    input  logic             addr_hit,
    input  logic             eof_valid,
    input  logic [LEN_W-1:0] frame_len,
    output logic             verdict_valid,
    output logic             verdict_accept
);
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

    logic hit_hold;
    logic hit_now;

    assign hit_now = hit_hold || (addr_done && addr_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_hold       <= 1'b0;
            verdict_valid  <= 1'b0;
            verdict_accept <= 1'b0;
        end else begin
            verdict_valid  <= eof_valid;
            verdict_accept <= eof_valid && hit_now && (frame_len >= MIN_L);
            if (restart || eof_valid) hit_hold <= 1'b0;
            else if (addr_done)       hit_hold <= addr_hit;
        end
    end

    assert_verdict_after_eof_R8: assert property (@(posedge clk) disable iff (rst)
        verdict_valid |-> $past(eof_valid));
    assert_accept_qualified_R8: assert property (@(posedge clk) disable iff (rst)
        verdict_accept |-> verdict_valid);
    assert_accept_min_len_R8: assert property (@(posedge clk) disable iff (rst)
        verdict_accept |-> ($past(frame_len) >= MIN_L));

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rxf_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [7:0]       in_byte,
    input  logic             eof_valid,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [3:0]       ctrl,
    input  logic [31:0]      uc0_lo,
    input  logic [15:0]      uc0_hi,
    input  logic [31:0]      uc1_lo,
    input  logic [15:0]      uc1_hi,
    input  logic [31:0]      tbl_lo,
    input  logic [31:0]      tbl_hi,
    output logic             match_valid,
    output logic             match_hit,
    output logic             verdict_valid,
    output logic             verdict_accept
);
    filt_ctrl_t c;
    mac_t       addr;
    logic       addr_done;
    logic       hit;

    assign c = filt_ctrl_t'(ctrl);

    rxf_addr_capture #(.BYTES(MAC_BYTES)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_byte   (in_byte),
        .addr      (addr),
        .addr_done (addr_done)
    );

    rxf_match u_match (
        .addr (addr),
        .ctrl (c),
        .uc0  (pack_addr(uc0_lo, uc0_hi)),
        .uc1  (pack_addr(uc1_lo, uc1_hi)),
        .tbl  ({tbl_hi, tbl_lo}),
        .hit  (hit)
    );

    rxf_verdict #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_verdict (
        .clk            (clk),
        .rst            (rst),
        .restart        (in_valid && in_sof),
        .addr_done      (addr_done),
        .addr_hit       (hit),
        .eof_valid      (eof_valid),
        .frame_len      (frame_len),
        .verdict_valid  (verdict_valid),
        .verdict_accept (verdict_accept)
    );

    assign match_valid = addr_done;
    assign match_hit   = addr_done && hit;

    assert_hit_only_when_valid_R7: assert property (@(posedge clk) disable iff (rst)
        match_hit |-> match_valid);
    assert_all_disabled_individual_R5: assert property (@(posedge clk) disable iff (rst)
        (match_valid && ctrl == 4'b0000 && !addr[0]) |-> !match_hit);
    assert_bcast_hit_R3: assert property (@(posedge clk) disable iff (rst)
        (match_valid && ctrl[3] && (&addr)) |-> match_hit);

endmodule

// File: tb/rx_dest_filter_test.sv
module rx_dest_filter_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_sof, eof_valid;
    logic [7:0]  in_byte;
    logic [15:0] frame_len;
    logic [3:0]  ctrl;
    logic [31:0] uc0_lo, uc1_lo, tbl_lo, tbl_hi;
    logic [15:0] uc0_hi, uc1_hi;
    logic        match_valid, match_hit, verdict_valid, verdict_accept;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    localparam logic [47:0] U0 = 48'h5A4B_3C2D_1E00;
    localparam logic [47:0] U1 = 48'h1122_3344_5566;
    localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;

    always #10 clk = ~clk;

    rx_dest_filter uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_byte(in_byte),
        .eof_valid(eof_valid), .frame_len(frame_len), .ctrl(ctrl),
        .uc0_lo(uc0_lo), .uc0_hi(uc0_hi), .uc1_lo(uc1_lo), .uc1_hi(uc1_hi),
        .tbl_lo(tbl_lo), .tbl_hi(tbl_hi), .match_valid(match_valid), .match_hit(match_hit),
        .verdict_valid(verdict_valid), .verdict_accept(verdict_accept)
    );

    task automatic chk(input logic got, input logic exp, input string req);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    function automatic logic [5:0] model_hash(input logic [47:0] a);
        logic [5:0] h = '0;
        for (int k = 0; k < 48; k++) h[k % 6] = h[k % 6] ^ a[k];
        return h;
    endfunction

    function automatic logic model_hit(input logic [47:0] a, input logic [3:0] c,
                                       input logic [63:0] t);
        logic r;
        r = (c[0] && a == U0) || (c[1] && a == U1) || (c[3] && a == BC);
        if ((a[0] || c[2]) && t[model_hash(a)]) r = 1'b1;
        return r;
    endfunction

    function automatic logic [47:0] next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed[47:0];
    endfunction

    task automatic set_tbl(input logic [63:0] t);
        tbl_lo = t[31:0];
        tbl_hi = t[63:32];
    endtask

    // Drives six bytes; returns at the negedge where match_valid is expected.
    task automatic send_addr(input logic [47:0] a);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_byte  = a[8*i +: 8];
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
    endtask

    task automatic close_frame(input int len, input logic exp_acc, input string req);
        eof_valid = 1'b1;
        frame_len = 16'(len);
        @(negedge clk);
        eof_valid = 1'b0;
        chk(verdict_valid, 1'b1, req);
        chk(verdict_accept, exp_acc, req);
    endtask

    task automatic run_frame(input logic [47:0] a, input int len, input string req);
        logic e;
        e = model_hit(a, ctrl, {tbl_hi, tbl_lo});
        send_addr(a);
        chk(match_valid, 1'b1, req);
        chk(match_hit, e, req);
        close_frame(len, e && (len >= 12), req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [47:0] a;
        logic [47:0] alist [6];
        logic [63:0] t;
        logic [5:0]  h;
        rst = 1'b1; in_valid = 0; in_sof = 0; in_byte = 0; eof_valid = 0; frame_len = 0;
        ctrl = 0;
        uc0_lo = U0[31:0]; uc0_hi = U0[47:32];
        uc1_lo = U1[31:0]; uc1_hi = U1[47:32];
        set_tbl(64'h0);
        repeat (3) @(negedge clk);
        chk(match_valid, 1'b0, "R10 reset");
        chk(match_hit, 1'b0, "R10 reset");
        chk(verdict_valid, 1'b0, "R10 reset");
        chk(verdict_accept, 1'b0, "R10 reset");
        rst = 1'b0;
        @(negedge clk);

        // R1 R2 R3 R5 R6 sweep over every control value and three table fills
        for (int c = 0; c < 16; c++) begin
            for (int tsel = 0; tsel < 3; tsel++) begin
                alist[0] = U0;
                alist[1] = U1;
                alist[2] = BC;
                alist[3] = next_rand() | 48'h1;
                alist[4] = next_rand() & ~48'h1;
                alist[5] = U0 ^ 48'h0100_0000_0000;
                for (int j = 0; j < 6; j++) begin
                    ctrl = 4'(c);
                    h = model_hash(alist[j]);
                    t = (tsel == 0) ? 64'h0 : (tsel == 1) ? '1 : (64'h1 << h);
                    set_tbl(t);
                    run_frame(alist[j], 11 + ((c + j + tsel) % 3), "R6 sweep R1 R2 R3 R5");
                end
            end
        end

        // R4 every hash position: selected entry hits, neighbour entry misses
        for (int i = 0; i < 64; i++) begin
            a = next_rand();
            h = model_hash(a);
            ctrl = 4'b0100;
            set_tbl(64'h1 << h);
            send_addr(a);
            chk(match_hit, 1'b1, "R4 hash index");
            close_frame(60, 1'b1, "R4 hash index");
            set_tbl(64'h1 << (h ^ 6'd1));
            send_addr(a);
            chk(match_hit, 1'b0, "R4 neighbour index");
            close_frame(60, 1'b0, "R4 neighbour index");
            ctrl = 4'b0000;
            set_tbl(64'h1 << model_hash(a & ~48'h1));
            send_addr(a & ~48'h1);
            chk(match_hit, 1'b0, "R5 individual not hashed");
            close_frame(60, 1'b0, "R5 individual not hashed");
        end

        // R7 extra byte after the sixth is ignored, no second pulse
        ctrl = 4'b0001; set_tbl(64'h0);
        send_addr(U0);
        chk(match_hit, 1'b1, "R7 first pulse");
        in_valid = 1'b1; in_byte = 8'hAA;
        @(negedge clk);
        in_valid = 1'b0;
        chk(match_valid, 1'b0, "R7 no second pulse");
        @(negedge clk);
        chk(match_valid, 1'b0, "R7 no second pulse");
        close_frame(64, 1'b1, "R7 extra byte ignored");

        // R7 bytes without a start-of-frame are ignored
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0; in_byte = U0[8*(i%6) +: 8];
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(match_valid, 1'b0, "R7 no sof");

        // R9 restart in the middle of an address
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (i == 0); in_byte = 8'h77;
        end
        send_addr(U0);
        chk(match_valid, 1'b1, "R9 restart");
        chk(match_hit, 1'b1, "R9 restart");
        close_frame(12, 1'b1, "R9 restart");

        // R9 restart discards an earlier hit before eof
        send_addr(U0);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (i == 0); in_byte = 8'h77;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        close_frame(60, 1'b0, "R9 partial after restart");

        // R8 length boundary
        send_addr(U0);
        close_frame(11, 1'b0, "R8 len 11");
        send_addr(U0);
        close_frame(12, 1'b1, "R8 len 12");
        send_addr(U1);
        close_frame(64, 1'b0, "R8 slot1 disabled");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule